// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and a calendar date. A counter divides a slow reference clock by a programmable integer to make a one-second tick. Each tick advances seconds, minutes and hours, and at midnight it advances the day of month, the month, the year and a free-running weekday counter. February gets a 29th day when the year is a multiple of four, unless a software override forces every year to be an ordinary one.

Software writes the whole time and date in one strobe. The block does not check or correct the loaded values. An alarm comparator looks at the fields selected by a per-field enable mask. When every selected field equals its programmed alarm value after a tick, the comparator sets a level interrupt. The interrupt stays high until a clear input is pulsed. Leaving some fields out of the mask gives a repeating alarm, for example once a minute or once a day.

Top module: `cal_rtc`

## Requirements
- R1: While `run_en` is high and no load is in progress, the time advances once every `div_reload`+1 clock cycles. A reload of 0 advances it every cycle. The reload port is 16 bits wide.
- R2: A cycle with `set_stb` high copies all seven `set_*` fields into the time registers and restarts the divider. The first advance comes `div_reload`+1 cycles after that load edge. A load takes priority over a tick in the same cycle.
- R3: While `run_en` is low, every time field holds its value.
- R4: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries one into the next field.
- R5: Day 31 ends January, March, May, July, August, October and December. Day 30 ends April, June, September and November. Month codes 0, 13, 14 and 15 use 31 days. After the last day, the day becomes 1 and the month increments. Month 12 rolls to month 1, and the year increments.
- R6: February 28 rolls to February 29 when year[1:0]==0 and `no_leap` is low. Otherwise it rolls to March 1. February 29 always rolls to March 1.
- R7: The leap-year choice uses the value of `no_leap` at the February 28 rollover tick only. Changing `no_leap` during February 29 does not stop February 29 from rolling to March 1.
- R8: The weekday code (0=Sunday … 6=Saturday) increments at each midnight, and 6 wraps to 0. It is never derived from the date.
- R9: Loaded values are not range-checked. A field above its limit increments by one modulo its width and produces no carry. For example, second 62 becomes 63 and then 0, and the minute does not change.
- R10: Mask bit positions in `alm_fld_en` are: 0 second, 1 minute, 2 hour, 3 weekday, 4 day, 5 month, 6 year. One cycle after a tick, `alm_irq` sets if every masked field equals its alarm value. An all-zero mask matches on every tick.
- R11: `alm_irq` stays high until `alm_clr` is high on a clock edge. That edge drives it low, and clear takes priority over a new match.
- R12: While `alm_glb_en` is low, `alm_irq` is driven low on the next edge and cannot be set.
- R13: After reset the time reads year 0, month 1, day 1, weekday 0, 00:00:00, and `alm_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Lets the divider and calendar advance |
| div_reload | input | DIV_W | Divide ratio minus one |
| no_leap | input | 1 | Forces every year to be a non-leap year |
| set_stb | input | 1 | Loads all `set_*` fields and restarts the divider |
| set_year | input | YEAR_W | Year to load |
| set_month | input | 4 | Month to load (1–12) |
| set_day | input | 5 | Day of month to load |
| set_dow | input | 3 | Weekday to load |
| set_hour | input | 5 | Hour to load |
| set_min | input | 6 | Minute to load |
| set_sec | input | 6 | Second to load |
| alm_glb_en | input | 1 | Global alarm enable |
| alm_fld_en | input | 7 | Per-field match mask |
| alm_year | input | YEAR_W | Alarm year |
| alm_month | input | 4 | Alarm month |
| alm_day | input | 5 | Alarm day |
| alm_dow | input | 3 | Alarm weekday |
| alm_hour | input | 5 | Alarm hour |
| alm_min | input | 6 | Alarm minute |
| alm_sec | input | 6 | Alarm second |
| alm_clr | input | 1 | Clears the alarm interrupt |
| now_year | output | YEAR_W | Current year |
| now_month | output | 4 | Current month |
| now_day | output | 5 | Current day of month |
| now_dow | output | 3 | Current weekday |
| now_hour | output | 5 | Current hour |
| now_min | output | 6 | Current minute |
| now_sec | output | 6 | Current second |
| alm_irq | output | 1 | Alarm interrupt level |

## Verification
The bench builds the block with its default widths: a 16-bit reload and a 12-bit year. It drives reload values 0, 2 and 300. A reload of 0 turns every cycle into one second. This brings a 25-hour run across a year boundary, and a sweep over every month, days 27 to 31, five years and both settings of the override, within a short run. Each result is compared against an arithmetic calendar model. Reloads of 2 and 300 place the first advance after a load on an exact cycle count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int DOW_W  = 3;
  localparam int NFLD   = 7;

  // alarm mask bit positions
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DOW  = 3;
  localparam int FLD_DAY  = 4;
  localparam int FLD_MON  = 5;
  localparam int FLD_YEAR = 6;

  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
  localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
  localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);
  localparam logic [DOW_W-1:0]  DOW_LAST  = DOW_W'(6);
  localparam logic [MON_W-1:0]  MON_FEB   = MON_W'(2);
  localparam logic [MON_W-1:0]  MON_LAST  = MON_W'(12);

  // last day for every month except February
  function automatic logic [DAY_W-1:0] month_end(input logic [MON_W-1:0] m);
    case (m)
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): month_end = DAY_W'(30);
      default:                                     month_end = DAY_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && !load && (cnt >= reload);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      cnt <= '0;
    end else if (en) begin
      if (cnt >= reload) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(cnt)); // R3
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int YEAR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic              no_leap,
  input  logic [YEAR_W-1:0] ld_year,
  input  logic [MON_W-1:0]  ld_month,
  input  logic [DAY_W-1:0]  ld_day,
  input  logic [DOW_W-1:0]  ld_dow,
  input  logic [HOUR_W-1:0] ld_hour,
  input  logic [MIN_W-1:0]  ld_min,
  input  logic [SEC_W-1:0]  ld_sec,
  output logic [YEAR_W-1:0] year,
  output logic [MON_W-1:0]  month,
  output logic [DAY_W-1:0]  day,
  output logic [DOW_W-1:0]  dow,
  output logic [HOUR_W-1:0] hour,
  output logic [MIN_W-1:0]  min,
  output logic [SEC_W-1:0]  sec
);
  logic sec_wrap, min_wrap, hour_wrap, day_wrap, leap_now;
  logic [DAY_W-1:0] day_nxt;

  always_comb begin
    sec_wrap  = (sec == SEC_LAST);
    min_wrap  = sec_wrap && (min == MIN_LAST);
    hour_wrap = min_wrap && (hour == HOUR_LAST);
    leap_now  = (year[1:0] == 2'b00) && !no_leap;
    day_wrap  = 1'b0;
    if (month == MON_FEB) begin
      if (day == DAY_W'(28))      day_wrap = !leap_now;
      else if (day == DAY_W'(29)) day_wrap = 1'b1;
    end else begin
      day_wrap = (day == month_end(month));
    end
    day_nxt = day_wrap ? DAY_W'(1) : day + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      year  <= '0;
      month <= MON_W'(1);
      day   <= DAY_W'(1);
      dow   <= '0;
      hour  <= '0;
      min   <= '0;
      sec   <= '0;
    end else if (load) begin
      year  <= ld_year;
      month <= ld_month;
      day   <= ld_day;
      dow   <= ld_dow;
      hour  <= ld_hour;
      min   <= ld_min;
      sec   <= ld_sec;
    end else if (tick) begin
      sec <= sec_wrap ? '0 : sec + 1'b1;
      if (sec_wrap) min <= (min == MIN_LAST) ? '0 : min + 1'b1;
      if (min_wrap) hour <= (hour == HOUR_LAST) ? '0 : hour + 1'b1;
      if (hour_wrap) begin
        day <= day_nxt;
        dow <= (dow == DOW_LAST) ? '0 : dow + 1'b1;
        if (day_wrap) begin
          month <= (month == MON_LAST) ? MON_W'(1) : month + 1'b1;
          if (month == MON_LAST) year <= year + 1'b1;
        end
      end
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> (sec == $past(ld_sec) && day == $past(ld_day) && year == $past(ld_year))); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> ($stable(sec) && $stable(min) && $stable(day) && $stable(year))); // R3
  AST_FEB29_EXIT: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && month == MON_FEB && day == DAY_W'(29) && hour == HOUR_LAST &&
     min == MIN_LAST && sec == SEC_LAST) |=> (month == MON_W'(3) && day == DAY_W'(1))); // R7
  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && dow == DOW_LAST && hour == HOUR_LAST && min == MIN_LAST &&
     sec == SEC_LAST) |=> (dow == '0)); // R8
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int YEAR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              glb_en,
  input  logic [NFLD-1:0]   fld_en,
  input  logic              clr,
  input  logic [YEAR_W-1:0] cur_year,
  input  logic [MON_W-1:0]  cur_month,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [DOW_W-1:0]  cur_dow,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [YEAR_W-1:0] tgt_year,
  input  logic [MON_W-1:0]  tgt_month,
  input  logic [DAY_W-1:0]  tgt_day,
  input  logic [DOW_W-1:0]  tgt_dow,
  input  logic [HOUR_W-1:0] tgt_hour,
  input  logic [MIN_W-1:0]  tgt_min,
  input  logic [SEC_W-1:0]  tgt_sec,
  output logic              irq
);
  logic            tick_q;
  logic [NFLD-1:0] eq;
  logic            hit;

  assign eq[FLD_SEC]  = (cur_sec   == tgt_sec);
  assign eq[FLD_MIN]  = (cur_min   == tgt_min);
  assign eq[FLD_HOUR] = (cur_hour  == tgt_hour);
  assign eq[FLD_DOW]  = (cur_dow   == tgt_dow);
  assign eq[FLD_DAY]  = (cur_day   == tgt_day);
  assign eq[FLD_MON]  = (cur_month == tgt_month);
  assign eq[FLD_YEAR] = (cur_year  == tgt_year);
  assign hit = &(eq | ~fld_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      tick_q <= tick;
      if (clr || !glb_en)    irq <= 1'b0;
      else if (tick_q && hit) irq <= 1'b1;
    end
  end

  AST_GLB_OFF: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !irq); // R12
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !irq); // R11
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr && glb_en) |=> irq); // R11
  AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!irq && !tick_q) |=> !irq); // R10
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import rtc_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int YEAR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [DIV_W-1:0]  div_reload,
  input  logic              no_leap,
  input  logic              set_stb,
  input  logic [YEAR_W-1:0] set_year,
  input  logic [MON_W-1:0]  set_month,
  input  logic [DAY_W-1:0]  set_day,
  input  logic [DOW_W-1:0]  set_dow,
  input  logic [HOUR_W-1:0] set_hour,
  input  logic [MIN_W-1:0]  set_min,
  input  logic [SEC_W-1:0]  set_sec,
  input  logic              alm_glb_en,
  input  logic [NFLD-1:0]   alm_fld_en,
  input  logic [YEAR_W-1:0] alm_year,
  input  logic [MON_W-1:0]  alm_month,
  input  logic [DAY_W-1:0]  alm_day,
  input  logic [DOW_W-1:0]  alm_dow,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [SEC_W-1:0]  alm_sec,
  input  logic              alm_clr,
  output logic [YEAR_W-1:0] now_year,
  output logic [MON_W-1:0]  now_month,
  output logic [DAY_W-1:0]  now_day,
  output logic [DOW_W-1:0]  now_dow,
  output logic [HOUR_W-1:0] now_hour,
  output logic [MIN_W-1:0]  now_min,
  output logic [SEC_W-1:0]  now_sec,
  output logic              alm_irq
);
  logic sec_tick;

  rtc_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(run_en), .load(set_stb),
    .reload(div_reload), .tick(sec_tick)
  );

  rtc_calendar #(.YEAR_W(YEAR_W)) u_cal (
    .clk(clk), .rst(rst), .tick(sec_tick), .load(set_stb), .no_leap(no_leap),
    .ld_year(set_year), .ld_month(set_month), .ld_day(set_day), .ld_dow(set_dow),
    .ld_hour(set_hour), .ld_min(set_min), .ld_sec(set_sec),
    .year(now_year), .month(now_month), .day(now_day), .dow(now_dow),
    .hour(now_hour), .min(now_min), .sec(now_sec)
  );

  rtc_alarm #(.YEAR_W(YEAR_W)) u_alm (
    .clk(clk), .rst(rst), .tick(sec_tick), .glb_en(alm_glb_en),
    .fld_en(alm_fld_en), .clr(alm_clr),
    .cur_year(now_year), .cur_month(now_month), .cur_day(now_day), .cur_dow(now_dow),
    .cur_hour(now_hour), .cur_min(now_min), .cur_sec(now_sec),
    .tgt_year(alm_year), .tgt_month(alm_month), .tgt_day(alm_day), .tgt_dow(alm_dow),
    .tgt_hour(alm_hour), .tgt_min(alm_min), .tgt_sec(alm_sec),
    .irq(alm_irq)
  );
endmodule

// File: tb/cal_rtc_bench.sv
`timescale 1ns/1ps
module cal_rtc_bench;
  typedef struct {
    int y; int mo; int d; int w; int h; int mi; int s;
  } tm_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic [15:0] div_reload = '0;
  logic        no_leap = 1'b0;
  logic        set_stb = 1'b0;
  logic [11:0] set_year = '0;
  logic [3:0]  set_month = 4'd1;
  logic [4:0]  set_day = 5'd1;
  logic [2:0]  set_dow = '0;
  logic [4:0]  set_hour = '0;
  logic [5:0]  set_min = '0;
  logic [5:0]  set_sec = '0;
  logic        alm_glb_en = 1'b0;
  logic [6:0]  alm_fld_en = '0;
  logic [11:0] alm_year = '0;
  logic [3:0]  alm_month = '0;
  logic [4:0]  alm_day = '0;
  logic [2:0]  alm_dow = '0;
  logic [4:0]  alm_hour = '0;
  logic [5:0]  alm_min = '0;
  logic [5:0]  alm_sec = '0;
  logic        alm_clr = 1'b0;
  logic [11:0] now_year;
  logic [3:0]  now_month;
  logic [4:0]  now_day;
  logic [2:0]  now_dow;
  logic [4:0]  now_hour;
  logic [5:0]  now_min;
  logic [5:0]  now_sec;
  logic        alm_irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cal_rtc u_cal_rtc (
    .clk(clk), .rst(rst), .run_en(run_en), .div_reload(div_reload), .no_leap(no_leap),
    .set_stb(set_stb), .set_year(set_year), .set_month(set_month), .set_day(set_day),
    .set_dow(set_dow), .set_hour(set_hour), .set_min(set_min), .set_sec(set_sec),
    .alm_glb_en(alm_glb_en), .alm_fld_en(alm_fld_en), .alm_year(alm_year),
    .alm_month(alm_month), .alm_day(alm_day), .alm_dow(alm_dow), .alm_hour(alm_hour),
    .alm_min(alm_min), .alm_sec(alm_sec), .alm_clr(alm_clr),
    .now_year(now_year), .now_month(now_month), .now_day(now_day), .now_dow(now_dow),
    .now_hour(now_hour), .now_min(now_min), .now_sec(now_sec), .alm_irq(alm_irq)
  );

  function automatic tm_t mk(int y, int mo, int d, int w, int h, int mi, int s);
    tm_t t;
    t.y = y; t.mo = mo; t.d = d; t.w = w; t.h = h; t.mi = mi; t.s = s;
    return t;
  endfunction

  // arithmetic calendar model, one second forward
  function automatic tm_t adv(tm_t t, bit nl);
    tm_t r = t;
    bit c_min, c_hr, c_day, c_mon, leap;
    int last;
    c_min = (t.s == 59);
    r.s = c_min ? 0 : (t.s + 1) % 64;
    if (!c_min) return r;
    c_hr = (t.mi == 59);
    r.mi = c_hr ? 0 : (t.mi + 1) % 64;
    if (!c_hr) return r;
    c_day = (t.h == 23);
    r.h = c_day ? 0 : (t.h + 1) % 32;
    if (!c_day) return r;
    r.w = (t.w == 6) ? 0 : (t.w + 1) % 8;
    leap = (t.y % 4 == 0) && !nl;
    if (t.mo == 2) begin
      if (t.d == 28)      c_mon = !leap;
      else if (t.d == 29) c_mon = 1'b1;
      else                c_mon = 1'b0;
    end else begin
      last = (t.mo == 4 || t.mo == 6 || t.mo == 9 || t.mo == 11) ? 30 : 31;
      c_mon = (t.d == last);
    end
    r.d = c_mon ? 1 : (t.d + 1) % 32;
    if (c_mon) begin
      r.mo = (t.mo == 12) ? 1 : (t.mo + 1) % 16;
      if (t.mo == 12) r.y = (t.y + 1) % 4096;
    end
    return r;
  endfunction

  function automatic tm_t now_t();
    return mk(int'(now_year), int'(now_month), int'(now_day), int'(now_dow),
              int'(now_hour), int'(now_min), int'(now_sec));
  endfunction

  function automatic string fmt(tm_t t);
    return $sformatf("%0d-%0d-%0d w%0d %0d:%0d:%0d", t.y, t.mo, t.d, t.w, t.h, t.mi, t.s);
  endfunction

  function automatic bit same(tm_t a, tm_t b);
    return a.y == b.y && a.mo == b.mo && a.d == b.d && a.w == b.w &&
           a.h == b.h && a.mi == b.mi && a.s == b.s;
  endfunction

  task automatic chk_t(string req, tm_t exp);
    tm_t act = now_t();
    checks++;
    if (!same(act, exp)) begin
      errors++;
      $display("FAIL %s time act=%s exp=%s", req, fmt(act), fmt(exp));
    end
  endtask

  task automatic chk_irq(string req, logic exp);
    checks++;
    if (alm_irq !== exp) begin
      errors++;
      $display("FAIL %s alm_irq act=%0b exp=%0b", req, alm_irq, exp);
    end
  endtask

  task automatic load_t(tm_t t);
    @(negedge clk);
    set_year = 12'(t.y); set_month = 4'(t.mo); set_day = 5'(t.d); set_dow = 3'(t.w);
    set_hour = 5'(t.h); set_min = 6'(t.mi); set_sec = 6'(t.s);
    set_stb = 1'b1;
    @(negedge clk);
    set_stb = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    tm_t t, e;
    string tag;
    wait_n(3);
    rst = 1'b0;
    @(negedge clk);
    // R13: reset state
    chk_t("R13", mk(0, 1, 1, 0, 0, 0, 0));
    chk_irq("R13", 1'b0);

    // R3 with R2: load while stopped, then time must hold
    t = mk(2010, 5, 17, 1, 8, 30, 15);
    load_t(t);
    chk_t("R2", t);
    wait_n(5);
    chk_t("R3", t);

    // R1/R2: reload 2 -> first advance on the third edge after the load edge
    div_reload = 16'd2;
    run_en = 1'b1;
    load_t(t);
    wait_n(1); chk_t("R2", t);
    wait_n(1); chk_t("R2", t);
    wait_n(1); e = adv(t, 1'b0); chk_t("R1", e);
    wait_n(2); chk_t("R1", e);
    wait_n(1); e = adv(e, 1'b0); chk_t("R1", e);

    // R1: reload 300 needs more than 8 bits
    div_reload = 16'd300;
    load_t(t);
    wait_n(300); chk_t("R1", t);
    wait_n(1);   chk_t("R1", adv(t, 1'b0));

    // R3: stop mid-run
    run_en = 1'b0;
    e = now_t();
    wait_n(400);
    chk_t("R3", e);

    // sweep of month ends with reload 0
    div_reload = 16'd0;
    run_en = 1'b1;
    for (int yi = 0; yi < 5; yi++) begin
      for (int nl = 0; nl < 2; nl++) begin
        for (int mo = 1; mo <= 12; mo++) begin
          for (int d = 27; d <= 31; d++) begin
            t = mk((yi == 4) ? 2100 : 2000 + yi, mo, d, 5, 23, 59, 59);
            no_leap = nl[0];
            load_t(t);
            wait_n(1);
            if (mo == 2) tag = "R6";
            else if (mo == 12) tag = "R5";
            else tag = "R5";
            chk_t(tag, adv(t, nl[0]));
          end
        end
      end
    end

    // R7: override sampled at the Feb 28 rollover itself
    no_leap = 1'b1;
    load_t(mk(2004, 2, 28, 2, 23, 59, 59));
    chk_t("R7", mk(2004, 2, 28, 2, 23, 59, 59));
    no_leap = 1'b0;
    wait_n(1);
    chk_t("R7", mk(2004, 2, 29, 3, 0, 0, 0));
    load_t(mk(2004, 2, 29, 3, 23, 59, 59));
    no_leap = 1'b1;
    wait_n(1);
    chk_t("R7", mk(2004, 3, 1, 4, 0, 0, 0));
    no_leap = 1'b0;

    // R9: out-of-range second, no clamp, no carry
    load_t(mk(2020, 6, 10, 3, 4, 7, 62));
    wait_n(1); chk_t("R9", mk(2020, 6, 10, 3, 4, 7, 63));
    wait_n(1); chk_t("R9", mk(2020, 6, 10, 3, 4, 7, 0));
    // R9: out-of-range hour 30 steps to 31 at minute wrap
    load_t(mk(2020, 6, 10, 3, 30, 59, 59));
    wait_n(1); chk_t("R9", mk(2020, 6, 10, 3, 31, 0, 0));

    // long run across midnight and a year boundary: R4 R5 R8
    t = mk(2003, 12, 31, 6, 22, 0, 0);
    load_t(t);
    for (int i = 0; i < 90000; i++) begin
      wait_n(1);
      t = adv(t, 1'b0);
      chk_t((t.h == 0 && t.mi == 0 && t.s == 0) ? "R8" : "R4", t);
    end

    // alarm on second 5 only (mask bit 0)
    alm_glb_en = 1'b0;
    alm_fld_en = 7'b0000001;
    alm_sec = 6'd5;
    load_t(mk(2030, 7, 4, 4, 10, 0, 0));
    alm_glb_en = 1'b1;
    wait_n(5); chk_irq("R10", 1'b0);
    wait_n(1); chk_irq("R10", 1'b1);
    wait_n(10); chk_irq("R11", 1'b1);
    alm_clr = 1'b1;
    wait_n(1);
    alm_clr = 1'b0;
    chk_irq("R11", 1'b0);
    wait_n(60); chk_irq("R10", 1'b1);

    // R12: global enable off
    alm_glb_en = 1'b0;
    wait_n(1); chk_irq("R12", 1'b0);
    wait_n(70); chk_irq("R12", 1'b0);

    // R10: masked weekday mismatch blocks, then match fires (mask bits 0 and 3)
    load_t(mk(2030, 7, 4, 2, 10, 0, 0));
    alm_fld_en = 7'b0001001;
    alm_dow = 3'd3;
    alm_glb_en = 1'b1;
    wait_n(70); chk_irq("R10", 1'b0);
    alm_dow = 3'd2;
    wait_n(70); chk_irq("R10", 1'b1);

    // R10: empty mask matches every tick; R11: clear dominates
    alm_glb_en = 1'b0;
    wait_n(1);
    alm_fld_en = 7'b0;
    alm_glb_en = 1'b1;
    wait_n(2); chk_irq("R10", 1'b1);
    alm_clr = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_n(1); chk_irq("R11", 1'b0);
    end
    alm_clr = 1'b0;
    wait_n(2); chk_irq("R11", 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule